// File: doc/BRIEF.md
# Four-Phase Instruction Fetch Sequencer

This block is the fetch front end of a small 8-bit controller. It splits the system clock into instruction cycles of four phases, T1 to T4. It holds the program counter and presents it as the fetch address. The program word read in T1 is latched, and at the T4 to T1 boundary it moves into the execute slot. In this way the word at the current counter value is fetched while the word fetched one cycle earlier executes.

The execute stage and the interrupt logic drive requests into the block: an interrupt with its vector, an absolute load (jump, call, return), a write of the low counter byte, and a conditional skip that was taken. The block samples these requests only in T4. Every honoured request throws away the prefetched word and puts a dummy slot in its place, so the instruction that caused it costs two cycles. Instruction decoding, the return-address stack and the program memory itself sit outside the block. The memory is read combinationally from the fetch address.

Top module: `fetch_seq`

## Requirements
- R1: `phase` counts 0,1,2,3 (T1..T4) and then wraps to 0 on every clock. The first cycle after reset is T1 (phase 0).
- R2: While `rstN` is low, and in the first instruction cycle after it rises, `fetchAddr` is 0, `execValid` is 0 and `execWord` is 0.
- R3: `fetchRead` is high exactly in T1. `fetchAddr` changes only at the T4 to T1 boundary.
- R4: With no request in T4, the counter advances by one, wrapping from 1023 to 0. The execute slot then receives the word read at the old counter value, with `execValid`=1 and `execAddr` set to that old value.
- R5: An interrupt (`irqReq`) in T4 loads `irqVector`, and an absolute load (`loadReq`) in T4 loads `loadAddr`. The next execute slot is a dummy: `execValid`=0 and `execWord`=0.
- R6: A low-byte write (`pclWrite`) in T4 replaces counter bits 7:0 with `pclData` and keeps bits 9:8. The next slot is a dummy.
- R7: A taken skip (`skipReq`) in T4 advances the counter by one and turns the next slot into a dummy.
- R8: When requests coincide, the order of priority is interrupt, then absolute load, then low-byte write, then skip. Any of them makes the slot a dummy.
- R9: Requests present only during T1 to T3 and removed before T4 have no effect. The counter advances by one and the slot is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqReq | input | 1 | Interrupt entry request |
| irqVector | input | 10 | Interrupt entry address |
| loadReq | input | 1 | Absolute load request (jump, call, return) |
| loadAddr | input | 10 | Absolute load target |
| pclWrite | input | 1 | Write of the low counter byte |
| pclData | input | 8 | New low counter byte |
| skipReq | input | 1 | Taken conditional skip |
| fetchAddr | output | 10 | Program counter / fetch address |
| fetchRead | output | 1 | Fetch strobe, high in T1 |
| memData | input | 14 | Program word at fetchAddr |
| phase | output | 2 | Current phase, 0=T1 .. 3=T4 |
| execWord | output | 14 | Word in the execute slot, 0 when dummy |
| execValid | output | 1 | Execute slot holds a real instruction |
| execAddr | output | 10 | Address of the word in the execute slot |

## Verification
The hardest case to reach from the ports is a request that must be ignored because it is withdrawn before T4. The bench aligns itself to phase 0 after reset. It raises a load request at mid-T1 and drops it at mid-T3, then checks that the counter only advances by one. A second directed case raises the request only at mid-T4 and expects the jump. A vector table drives coinciding requests to check each level of the priority chain. It also covers the counter wrap at 1023 and low-byte writes in both the low and high pages.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  typedef enum logic [1:0] {
    PH_T1 = 2'd0,
    PH_T2 = 2'd1,
    PH_T3 = 2'd2,
    PH_T4 = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    SRC_SEQ  = 2'd0,
    SRC_IRQ  = 2'd1,
    SRC_JUMP = 2'd2,
    SRC_PAGE = 2'd3
  } pcSrc_e;

  // control -> datapath strobes
  typedef struct packed {
    logic   capture;  // latch program word (T1)
    logic   advance;  // T4 -> T1 boundary
    logic   flush;    // replace prefetched word by a dummy slot
    pcSrc_e src;      // next counter source
  } strobe_t;

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    irqReq,
  input  logic    loadReq,
  input  logic    pclWrite,
  input  logic    skipReq,
  output phase_e  phaseQ,
  output strobe_t strobes
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= PH_T1;
    else       phaseQ <= phase_e'(phaseQ + 2'd1);
  end

  logic anyReq;
  assign anyReq = irqReq | loadReq | pclWrite | skipReq;

  always_comb begin
    strobes         = '0;
    strobes.src     = SRC_SEQ;
    strobes.capture = (phaseQ == PH_T1);
    strobes.advance = (phaseQ == PH_T4);
    strobes.flush   = strobes.advance && anyReq;
    if (strobes.advance) begin
      if (irqReq)        strobes.src = SRC_IRQ;
      else if (loadReq)  strobes.src = SRC_JUMP;
      else if (pclWrite) strobes.src = SRC_PAGE;
      else               strobes.src = SRC_SEQ;
    end
  end

endmodule

// File: rtl/fetch_dp.sv
module fetch_dp
  import fetch_pkg::*;
#(
  parameter int PC_W   = 10,
  parameter int WORD_W = 14,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [PC_W-1:0]   irqVector,
  input  logic [PC_W-1:0]   loadAddr,
  input  logic [PAGE_W-1:0] pclData,
  input  logic [WORD_W-1:0] memData,
  output logic [PC_W-1:0]   pcQ,
  output logic [WORD_W-1:0] execWord,
  output logic              execValid,
  output logic [PC_W-1:0]   execAddr
);

  localparam int HI_W = PC_W - PAGE_W;

  logic [WORD_W-1:0] fetchBuf;
  logic [PC_W-1:0]   pageTarget;
  logic [PC_W-1:0]   nextPc;

  generate
    if (HI_W > 0) begin : g_paged
      assign pageTarget = {pcQ[PC_W-1:PAGE_W], pclData};
    end else begin : g_flat
      assign pageTarget = pclData[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (strobes.src)
      SRC_IRQ:  nextPc = irqVector;
      SRC_JUMP: nextPc = loadAddr;
      SRC_PAGE: nextPc = pageTarget;
      default:  nextPc = pcQ + PC_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ       <= '0;
      fetchBuf  <= '0;
      execWord  <= '0;
      execValid <= 1'b0;
      execAddr  <= '0;
    end else begin
      if (strobes.capture) fetchBuf <= memData;
      if (strobes.advance) begin
        pcQ       <= nextPc;
        execAddr  <= pcQ;
        execValid <= !strobes.flush;
        execWord  <= strobes.flush ? '0 : fetchBuf;
      end
    end
  end

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_pkg::*;
#(
  parameter int PC_W   = 10,
  parameter int WORD_W = 14,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqReq,
  input  logic [PC_W-1:0]   irqVector,
  input  logic              loadReq,
  input  logic [PC_W-1:0]   loadAddr,
  input  logic              pclWrite,
  input  logic [PAGE_W-1:0] pclData,
  input  logic              skipReq,
  output logic [PC_W-1:0]   fetchAddr,
  output logic              fetchRead,
  input  logic [WORD_W-1:0] memData,
  output logic [1:0]        phase,
  output logic [WORD_W-1:0] execWord,
  output logic              execValid,
  output logic [PC_W-1:0]   execAddr
);

  phase_e  phaseQ;
  strobe_t strobes;

  fetch_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .irqReq  (irqReq),
    .loadReq (loadReq),
    .pclWrite(pclWrite),
    .skipReq (skipReq),
    .phaseQ  (phaseQ),
    .strobes (strobes)
  );

  fetch_dp #(.PC_W(PC_W), .WORD_W(WORD_W), .PAGE_W(PAGE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .irqVector(irqVector),
    .loadAddr (loadAddr),
    .pclData  (pclData),
    .memData  (memData),
    .pcQ      (fetchAddr),
    .execWord (execWord),
    .execValid(execValid),
    .execAddr (execAddr)
  );

  assign fetchRead = strobes.capture;
  assign phase     = phaseQ;

endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
  parameter int PC_W   = 10,
  parameter int WORD_W = 14,
  parameter int PAGE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              irqReq,
  input logic [PC_W-1:0]   irqVector,
  input logic              loadReq,
  input logic [PC_W-1:0]   loadAddr,
  input logic              pclWrite,
  input logic              skipReq,
  input logic [PC_W-1:0]   fetchAddr,
  input logic              fetchRead,
  input logic [1:0]        phase,
  input logic [WORD_W-1:0] execWord,
  input logic              execValid
);

  p_phase_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd3) |=> (phase == 2'd0));

  p_phase_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (phase != 2'd3) |=> (phase == 2'($past(phase) + 2'd1)));

  p_strobe_t1_r3: assert property (@(posedge clk) disable iff (!rstN)
    fetchRead |-> (phase == 2'd0));

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (phase != 2'd3) |=> $stable(fetchAddr));

  p_irq_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd3 && irqReq) |=> (fetchAddr == $past(irqVector) && !execValid));

  p_jump_r8: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd3 && !irqReq && loadReq) |=> (fetchAddr == $past(loadAddr) && !execValid));

  p_pcl_page_r6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd3 && !irqReq && !loadReq && pclWrite)
      |=> (fetchAddr[PC_W-1:PAGE_W] == $past(fetchAddr[PC_W-1:PAGE_W]) && !execValid));

  p_skip_dummy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd3 && !irqReq && !loadReq && !pclWrite && skipReq)
      |=> (fetchAddr == PC_W'($past(fetchAddr) + 1) && !execValid));

  p_dummy_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    !execValid |-> (execWord == '0));

endmodule

bind fetch_seq fetch_seq_chk #(.PC_W(PC_W), .WORD_W(WORD_W), .PAGE_W(PAGE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .irqReq   (irqReq),
  .irqVector(irqVector),
  .loadReq  (loadReq),
  .loadAddr (loadAddr),
  .pclWrite (pclWrite),
  .skipReq  (skipReq),
  .fetchAddr(fetchAddr),
  .fetchRead(fetchRead),
  .phase    (phase),
  .execWord (execWord),
  .execValid(execValid)
);

// File: tb/sim_fetch_seq.sv
module sim_fetch_seq;

  localparam int PERIOD = 10;
  localparam int NVEC   = 18;

  typedef struct packed {
    logic       irq;
    logic [9:0] vec;
    logic       ld;
    logic [9:0] ldA;
    logic       pcl;
    logic [7:0] pclD;
    logic       skip;
    logic [9:0] expPc;
    logic       expValid;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 8'h00, 1'b0, 10'h001, 1'b1},
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 8'h00, 1'b0, 10'h002, 1'b1},
    '{1'b0, 10'h000, 1'b1, 10'h155, 1'b0, 8'h00, 1'b0, 10'h155, 1'b0},
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 8'h00, 1'b0, 10'h156, 1'b1},
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 8'h00, 1'b1, 10'h157, 1'b0},
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 8'h00, 1'b0, 10'h158, 1'b1},
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b1, 8'h20, 1'b0, 10'h120, 1'b0},
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 8'h00, 1'b0, 10'h121, 1'b1},
    '{1'b1, 10'h004, 1'b1, 10'h3FF, 1'b1, 8'h33, 1'b1, 10'h004, 1'b0},
    '{1'b0, 10'h000, 1'b1, 10'h3FE, 1'b1, 8'h10, 1'b1, 10'h3FE, 1'b0},
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 8'h00, 1'b0, 10'h3FF, 1'b1},
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 8'h00, 1'b0, 10'h000, 1'b1},
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b1, 8'hFF, 1'b1, 10'h0FF, 1'b0},
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 8'h00, 1'b0, 10'h100, 1'b1},
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 8'h00, 1'b1, 10'h101, 1'b0},
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 8'h00, 1'b1, 10'h102, 1'b0},
    '{1'b0, 10'h000, 1'b1, 10'h3C0, 1'b0, 8'h00, 1'b0, 10'h3C0, 1'b0},
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b1, 8'h05, 1'b0, 10'h305, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irqReq = 1'b0;
  logic [9:0]  irqVector = '0;
  logic        loadReq = 1'b0;
  logic [9:0]  loadAddr = '0;
  logic        pclWrite = 1'b0;
  logic [7:0]  pclData = '0;
  logic        skipReq = 1'b0;
  logic [9:0]  fetchAddr;
  logic        fetchRead;
  logic [13:0] memData;
  logic [1:0]  phase;
  logic [13:0] execWord;
  logic        execValid;
  logic [9:0]  execAddr;

  int nChecks = 0;
  int nFails  = 0;

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [13:0] romWord(input logic [9:0] a);
    return {a[3:0] ^ 4'h9, a};
  endfunction

  assign memData = romWord(fetchAddr);

  fetch_seq u0 (
    .clk(clk), .rstN(rstN),
    .irqReq(irqReq), .irqVector(irqVector),
    .loadReq(loadReq), .loadAddr(loadAddr),
    .pclWrite(pclWrite), .pclData(pclData),
    .skipReq(skipReq),
    .fetchAddr(fetchAddr), .fetchRead(fetchRead), .memData(memData),
    .phase(phase), .execWord(execWord), .execValid(execValid), .execAddr(execAddr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearReqs();
    irqReq = 0; loadReq = 0; pclWrite = 0; skipReq = 0;
  endtask

  // One instruction cycle; entered at mid-T1, leaves at mid-T1 of the next.
  task automatic runCycle(input vec_t v, input string tag);
    logic [9:0] startPc;
    logic       phaseOk;
    startPc = fetchAddr;
    phaseOk = (phase == 2'd0) && fetchRead;
    irqReq = v.irq; irqVector = v.vec; loadReq = v.ld; loadAddr = v.ldA;
    pclWrite = v.pcl; pclData = v.pclD; skipReq = v.skip;
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      if (phase != 2'(k) || fetchRead || fetchAddr != startPc) phaseOk = 1'b0;
    end
    @(negedge clk);
    clearReqs();
    check("R1/R3 phase walk and strobe", {31'd0, phaseOk}, 32'd1);
    check({tag, " pc"}, {22'd0, fetchAddr}, {22'd0, v.expPc});
    check({tag, " valid"}, {31'd0, execValid}, {31'd0, v.expValid});
    check({tag, " R4 execAddr"}, {22'd0, execAddr}, {22'd0, startPc});
    check({tag, " word"}, {18'd0, execWord},
          v.expValid ? {18'd0, romWord(startPc)} : 32'd0);
  endtask

  function automatic string vecTag(input vec_t v);
    if (v.irq)  return "R8/R5 irq";
    if (v.ld)   return (v.pcl || v.skip) ? "R8 load" : "R5 load";
    if (v.pcl)  return v.skip ? "R8 pcl R6" : "R6 pcl";
    if (v.skip) return "R7 skip";
    return "R4 seq";
  endfunction

  task automatic doReset();
    rstN = 0;
    repeat (3) @(negedge clk);
    check("R2 reset pc", {22'd0, fetchAddr}, 32'd0);
    check("R2 reset valid", {31'd0, execValid}, 32'd0);
    rstN = 1;
    check("R2 reset phase", {30'd0, phase}, 32'd0);
    check("R2 reset word", {18'd0, execWord}, 32'd0);
  endtask

  initial begin
    #(PERIOD * 200000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    vec_t v;
    @(negedge clk);
    doReset();

    // first cycle after reset: slot still dummy during it
    check("R2 first slot dummy", {31'd0, execValid}, 32'd0);

    for (int i = 0; i < NVEC; i++) runCycle(VECS[i], vecTag(VECS[i]));

    // R9: load raised T1..T3 only, dropped before T4
    begin
      logic [9:0] p0;
      p0 = fetchAddr;
      loadReq = 1; loadAddr = 10'h2AA;
      @(negedge clk); @(negedge clk);
      loadReq = 0;
      @(negedge clk); @(negedge clk);
      check("R9 early load ignored pc", {22'd0, fetchAddr}, {22'd0, 10'(p0 + 1)});
      check("R9 early load slot valid", {31'd0, execValid}, 32'd1);
    end

    // R5: load held only in T4 is honoured
    begin
      repeat (3) @(negedge clk);
      loadReq = 1; loadAddr = 10'h0AB;
      @(negedge clk);
      loadReq = 0;
      check("R5 T4-only load pc", {22'd0, fetchAddr}, 32'h0AB);
      check("R5 T4-only load dummy", {31'd0, execValid}, 32'd0);
    end

    // R4: plain step after the T4-only load
    v = '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 8'h00, 1'b0, 10'h0AC, 1'b1};
    runCycle(v, "R4 seq after jump");

    // R2: reset in the middle of a cycle
    @(negedge clk);
    doReset();
    v = '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 8'h00, 1'b0, 10'h001, 1'b1};
    runCycle(v, "R2 restart R4");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule